// File: doc/BRIEF.md
# Control-Flow Redirect and Squash Unit

This unit sits beside the execute stage of a five-stage, in-order pipeline and owns the fetch program counter. Instruction space is byte addressed. It starts at byte 4000 and each instruction is 4 bytes wide, so the unit steps the counter by 4 in every cycle in which nothing else intervenes.

Conditional branches carry a signed literal that is added to their own PC. One branch kind fires when the zero flag is set, and the other fires when the flag is clear. The register jump adds the literal to a register operand and always fires. The decision and the destination are both formed in execute.

A redirect squashes the two younger slots, fetch and decode, in the same cycle that the destination enters the fetch counter. When a halt is seen in decode, fetch freezes while the older instructions drain. The halt then reports completion once it reaches writeback. A destination that is not on a 4-byte boundary, or that lies below the base of instruction space, is refused and recorded in a sticky error flag.

Top module: `ctl_redirect_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the unit resets to fetch_pc = 4000 with halted, done and target_err at 0. With no control instruction in execute, redirect_taken and flush_fd read 0.
- R2: In a running cycle with no redirect, no accepted halt and fetch_hold = 0, fetch_pc increases by 4 at the next edge. With fetch_hold = 1 and no redirect, fetch_pc keeps its value.
- R3: The branch-if-zero kind (ex_kind = 1) is taken when zero_flag = 1, with target ex_pc + ex_lit, where ex_lit is two's complement. With zero_flag = 0 it is not taken.
- R4: The branch-if-not-zero kind (ex_kind = 2) is taken when zero_flag = 0, with target ex_pc + ex_lit. With zero_flag = 1 it is not taken.
- R5: The register jump (ex_kind = 3) is taken regardless of zero_flag, with target ex_opnd + ex_lit.
- R6: A taken redirect drives redirect_taken = 1 and flush_fd = 1 combinationally in its execute cycle. fetch_pc equals the target after the next edge, even if fetch_hold = 1. With ex_kind = 0 or ex_valid = 0, nothing is taken.
- R7: If the condition is met but the target has a nonzero value in bits [1:0], or is below 4000 when compared unsigned, the instruction is not taken and nothing is flushed. Fetch continues sequentially, and target_err rises at the next edge and stays at 1 until reset.
- R8: dec_halt in a running cycle with no taken redirect sets halted = 1 at the next edge. From that edge fetch_pc stops advancing. dec_halt in the same cycle as a taken redirect is ignored, and the redirect proceeds.
- R9: While halted = 1, the execute inputs have no effect: redirect_taken and flush_fd stay 0, target_err does not change, and fetch_pc stays stable.
- R10: wb_halt while halted sets done = 1 at the next edge, and done stays at 1 until reset. wb_halt while not halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_hold | input | 1 | Interlock stall: keep the fetch PC |
| dec_halt | input | 1 | A halt instruction is in decode |
| ex_valid | input | 1 | Execute slot holds a live instruction |
| ex_kind | input | 2 | Control kind in execute: 0 none, 1 branch-if-zero, 2 branch-if-not-zero, 3 register jump |
| ex_pc | input | 32 | Byte address of the instruction in execute |
| ex_lit | input | 32 | Signed literal of that instruction |
| ex_opnd | input | 32 | Register operand used by the jump |
| zero_flag | input | 1 | Architectural zero flag, already up to date |
| wb_halt | input | 1 | The halt instruction is in writeback |
| fetch_pc | output | 32 | Address fetch uses in this cycle |
| redirect_taken | output | 1 | A control transfer is taken this cycle |
| flush_fd | output | 1 | Turn the fetch and decode slots into bubbles |
| halted | output | 1 | Fetch is frozen by a halt |
| done | output | 1 | The halt has reached writeback |
| target_err | output | 1 | Sticky: a refused, badly formed target was seen |

## Verification
The bench drives negative literals that move the target backwards, and a target exactly at 4000. A design that used unsigned literal arithmetic, or an off-by-one lower bound, would land on the wrong address or reject that legal target. It also drives misaligned targets, and one below the base. A design that checked the target only for taken branches would still redirect, and one whose error was not sticky would lose the flag.

A halt is presented in the same cycle as a taken branch in execute. A design that froze fetch on that halt would hang the core on an instruction that should have been squashed. Execute inputs arriving after the freeze are also covered, as are a redirect during an interlock hold and a writeback halt before any freeze. A wrong design would respectively keep moving the PC, miss the destination, or end the run early.

// File: rtl/ctl_redirect_pkg.sv
// Shared types for the control-flow redirect unit.
// Assumes a 2-bit control kind code from decode; the values are part of the port contract.
package ctl_redirect_pkg;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_BZ   = 2'd1,
        CK_BNZ  = 2'd2,
        CK_JUMP = 2'd3
    } ctl_kind_e;

    typedef enum logic [1:0] {
        FS_RUN    = 2'd0,
        FS_FROZEN = 2'd1,
        FS_DONE   = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/ctl_target_calc.sv
// Forms the control-transfer destination and judges whether it is legal.
// Assumes two's complement wrap on the 32-bit sum; only alignment and the lower
// bound of instruction space are checked.
module ctl_target_calc
    import ctl_redirect_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int BASE = 4000,
    parameter int ISZ  = 4
) (
    input  ctl_kind_e         kind,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   lit,
    input  logic [XLEN-1:0]   opnd,
    output logic [XLEN-1:0]   target,
    output logic              target_ok
);
    localparam int ALIGN_BITS = $clog2(ISZ);
    localparam logic [XLEN-1:0] BASE_ADDR = XLEN'(BASE);

    logic aligned;
    logic in_space;

    // Pick the addend: register operand for jumps, own PC for branches.
    always_comb begin
        if (kind == CK_JUMP) target = opnd + lit;
        else                 target = pc + lit;
    end

    generate
        if (ALIGN_BITS == 0) begin : g_no_align
            assign aligned = 1'b1;
        end else begin : g_align
            assign aligned = (target[ALIGN_BITS-1:0] == '0);
        end
    endgenerate

    // Legal only on an instruction boundary at or above the base.
    always_comb begin
        in_space  = (target >= BASE_ADDR);
        target_ok = aligned && in_space;
    end

endmodule

// File: rtl/ctl_taken_decide.sv
// Decides whether the control instruction in execute transfers control.
// Assumes zero_flag is current (interlock resolved) and `running` is low once fetch froze.
module ctl_taken_decide
    import ctl_redirect_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  ctl_kind_e kind,
    input  logic      zero_flag,
    input  logic      running,
    input  logic      target_ok,
    output logic      cond_met,
    output logic      taken,
    output logic      err_set
);
    // Evaluate the branch condition for the kind in execute.
    always_comb begin
        unique case (kind)
            CK_BZ:   cond_met = zero_flag;
            CK_BNZ:  cond_met = !zero_flag;
            CK_JUMP: cond_met = 1'b1;
            default: cond_met = 1'b0;
        endcase
    end

    // A met condition either redirects or, with a bad target, raises an error.
    always_comb begin
        taken   = valid && running && cond_met && target_ok;
        err_set = valid && running && cond_met && !target_ok;
    end

    assert_taken_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && err_set));
    assert_none_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_NONE) |-> !taken);

endmodule

// File: rtl/ctl_fetch_pc.sv
// Fetch program counter: loads a redirect, steps by one instruction, or holds.
// Assumes load has priority over any hold request.
module ctl_fetch_pc #(
    parameter int XLEN = 32,
    parameter int BASE = 4000,
    parameter int ISZ  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] target,
    input  logic            advance,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP      = XLEN'(ISZ);
    localparam logic [XLEN-1:0] RESET_VAL = XLEN'(BASE);

    // Update the counter once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= RESET_VAL;
        else if (load)    pc <= target;
        else if (advance) pc <= pc + STEP;
    end

endmodule

// File: rtl/ctl_halt_fsm.sv
// Tracks halt progress: running, frozen after a halt in decode, done at writeback.
// Assumes halt_accept is already qualified against a same-cycle squash.
module ctl_halt_fsm
    import ctl_redirect_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_accept,
    input  logic wb_halt,
    output logic running,
    output logic halted,
    output logic done
);
    fetch_state_e state;

    // Advance the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_RUN;
        else begin
            unique case (state)
                FS_RUN:    if (halt_accept) state <= FS_FROZEN;
                FS_FROZEN: if (wb_halt)     state <= FS_DONE;
                default:   state <= FS_DONE;
            endcase
        end
    end

    // Decode state into flags.
    always_comb begin
        running = (state == FS_RUN);
        halted  = (state != FS_RUN);
        done    = (state == FS_DONE);
    end

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/ctl_redirect_unit.sv
// Top of the execute-stage control-flow unit: resolves branches and jumps,
// steers fetch, squashes younger slots and freezes fetch on halt.
// Assumes a single control instruction in execute per cycle and a current zero flag.
module ctl_redirect_unit
    import ctl_redirect_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int BASE = 4000,
    parameter int ISZ  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_hold,
    input  logic            dec_halt,
    input  logic            ex_valid,
    input  logic [1:0]      ex_kind,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] ex_lit,
    input  logic [XLEN-1:0] ex_opnd,
    input  logic            zero_flag,
    input  logic            wb_halt,
    output logic [XLEN-1:0] fetch_pc,
    output logic            redirect_taken,
    output logic            flush_fd,
    output logic            halted,
    output logic            done,
    output logic            target_err
);
    localparam int ALIGN_BITS = $clog2(ISZ);
    localparam logic [XLEN-1:0] BASE_ADDR = XLEN'(BASE);
    localparam logic [XLEN-1:0] STEP      = XLEN'(ISZ);

    ctl_kind_e       kind;
    logic [XLEN-1:0] target;
    logic            target_ok;
    logic            cond_met;
    logic            taken;
    logic            err_set;
    logic            running;
    logic            halt_accept;
    logic            advance;

    assign kind = ctl_kind_e'(ex_kind);

    ctl_target_calc #(.XLEN(XLEN), .BASE(BASE), .ISZ(ISZ)) u_calc (
        .kind      (kind),
        .pc        (ex_pc),
        .lit       (ex_lit),
        .opnd      (ex_opnd),
        .target    (target),
        .target_ok (target_ok)
    );

    ctl_taken_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (ex_valid),
        .kind      (kind),
        .zero_flag (zero_flag),
        .running   (running),
        .target_ok (target_ok),
        .cond_met  (cond_met),
        .taken     (taken),
        .err_set   (err_set)
    );

    // A halt in decode is younger than execute: a taken redirect squashes it.
    always_comb begin
        halt_accept = running && dec_halt && !taken;
        advance     = running && !halt_accept && !fetch_hold;
    end

    ctl_fetch_pc #(.XLEN(XLEN), .BASE(BASE), .ISZ(ISZ)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (taken),
        .target  (target),
        .advance (advance),
        .pc      (fetch_pc)
    );

    ctl_halt_fsm u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_accept (halt_accept),
        .wb_halt     (wb_halt),
        .running     (running),
        .halted      (halted),
        .done        (done)
    );

    // Latch refused-target events until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       target_err <= 1'b0;
        else if (err_set) target_err <= 1'b1;
    end

    // Drive redirect and squash together.
    always_comb begin
        redirect_taken = taken;
        flush_fd       = taken;
    end

    assert_redirect_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_taken |=> fetch_pc == $past(target));
    assert_legal_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_taken |-> (target[ALIGN_BITS-1:0] == '0) && (target >= BASE_ADDR));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        target_err |=> target_err);
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_taken && !halted && !dec_halt && !fetch_hold) |=> fetch_pc == $past(fetch_pc) + STEP);
    assert_frozen_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !redirect_taken && !flush_fd);
    assert_frozen_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(fetch_pc));
    assert_done_needs_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> halted);

endmodule

// File: tb/ctl_redirect_unit_tb.sv
`timescale 1ns/1ps
module ctl_redirect_unit_tb;

    localparam int PERIOD = 20;

    typedef struct packed {
        logic [1:0]  kind;
        logic        zf;
        logic [31:0] pc;
        logic [31:0] lit;
        logic [31:0] opnd;
        logic        exp_taken;
        logic [31:0] exp_tgt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1, 32'd4020, -32'sd8,   32'd0,    1'b1, 32'd4012}, // R3 backward
        '{2'd1, 1'b0, 32'd4020, 32'd8,     32'd0,    1'b0, 32'd0},    // R3 not taken
        '{2'd2, 1'b0, 32'd4100, 32'd24,    32'd0,    1'b1, 32'd4124}, // R4 taken
        '{2'd2, 1'b1, 32'd4100, -32'sd4,   32'd0,    1'b0, 32'd0},    // R4 not taken
        '{2'd3, 1'b0, 32'd0,    32'd40,    32'd4000, 1'b1, 32'd4040}, // R5
        '{2'd3, 1'b1, 32'd0,    -32'sd100, 32'd4200, 1'b1, 32'd4100}, // R5 negative
        '{2'd0, 1'b1, 32'd4000, 32'd4,     32'd0,    1'b0, 32'd0},    // R6 none kind
        '{2'd1, 1'b1, 32'd4004, -32'sd4,   32'd0,    1'b1, 32'd4000}, // R3 exact base
        '{2'd1, 1'b0, 32'd4000, 32'd2,     32'd0,    1'b0, 32'd0},    // R7 bad but cond false
        '{2'd2, 1'b0, 32'd5000, -32'sd996, 32'd0,    1'b1, 32'd4004}  // R4 backward
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_hold = 1'b0, dec_halt = 1'b0, ex_valid = 1'b0, zero_flag = 1'b0, wb_halt = 1'b0;
    logic [1:0]  ex_kind = 2'd0;
    logic [31:0] ex_pc = '0, ex_lit = '0, ex_opnd = '0;
    logic [31:0] fetch_pc;
    logic        redirect_taken, flush_fd, halted, done, target_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] prev;

    always #(PERIOD/2) clk = ~clk;

    ctl_redirect_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_hold(fetch_hold), .dec_halt(dec_halt),
        .ex_valid(ex_valid), .ex_kind(ex_kind), .ex_pc(ex_pc), .ex_lit(ex_lit),
        .ex_opnd(ex_opnd), .zero_flag(zero_flag), .wb_halt(wb_halt),
        .fetch_pc(fetch_pc), .redirect_taken(redirect_taken), .flush_fd(flush_fd),
        .halted(halted), .done(done), .target_err(target_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ex_valid = 1'b0; dec_halt = 1'b0; wb_halt = 1'b0; fetch_hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive_ex(input logic [1:0] k, input logic zf, input logic [31:0] pc,
                            input logic [31:0] lit, input logic [31:0] op);
        ex_valid = 1'b1; ex_kind = k; zero_flag = zf; ex_pc = pc; ex_lit = lit; ex_opnd = op;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk(fetch_pc, 32'd4000, "R1 fetch_pc");
        chk({31'd0, halted}, 0, "R1 halted");
        chk({31'd0, done}, 0, "R1 done");
        chk({31'd0, target_err}, 0, "R1 target_err");
        chk({31'd0, redirect_taken}, 0, "R1 taken");

        // R2: sequential stepping, then hold
        @(negedge clk);
        chk(fetch_pc, 32'd4004, "R2 step1");
        @(negedge clk);
        chk(fetch_pc, 32'd4008, "R2 step2");
        fetch_hold = 1'b1;
        @(negedge clk);
        chk(fetch_pc, 32'd4008, "R2 hold");
        // R6: redirect overrides hold
        drive_ex(2'd3, 1'b0, 32'd0, 32'd8, 32'd4400);
        @(negedge clk);
        chk(fetch_pc, 32'd4408, "R6 redirect over hold");
        fetch_hold = 1'b0;
        // R6: invalid slot ignored
        ex_valid = 1'b0;
        prev = fetch_pc;
        #1;
        chk({31'd0, redirect_taken}, 0, "R6 invalid not taken");
        @(negedge clk);
        chk(fetch_pc, prev + 4, "R6 invalid sequential");

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            drive_ex(VECS[i].kind, VECS[i].zf, VECS[i].pc, VECS[i].lit, VECS[i].opnd);
            #1;
            chk({31'd0, redirect_taken}, {31'd0, VECS[i].exp_taken}, $sformatf("R3/R4/R5 taken v%0d", i));
            chk({31'd0, flush_fd}, {31'd0, VECS[i].exp_taken}, $sformatf("R6 flush v%0d", i));
            prev = fetch_pc;
            @(negedge clk);
            chk(fetch_pc, VECS[i].exp_taken ? VECS[i].exp_tgt : prev + 4, $sformatf("R6 next pc v%0d", i));
            chk({31'd0, target_err}, 0, $sformatf("R7 no err v%0d", i));
            ex_valid = 1'b0;
            @(negedge clk);
        end

        // R7: misaligned jump refused, sticky error
        drive_ex(2'd3, 1'b0, 32'd0, 32'd2, 32'd4000);
        #1;
        chk({31'd0, redirect_taken}, 0, "R7 misaligned not taken");
        chk({31'd0, flush_fd}, 0, "R7 misaligned no flush");
        prev = fetch_pc;
        @(negedge clk);
        ex_valid = 1'b0;
        chk(fetch_pc, prev + 4, "R7 sequential after refuse");
        chk({31'd0, target_err}, 1, "R7 err set");
        @(negedge clk);
        @(negedge clk);
        chk({31'd0, target_err}, 1, "R7 err sticky");

        // R7: below base refused
        do_reset();
        drive_ex(2'd1, 1'b1, 32'd4000, -32'sd4, 32'd0);
        #1;
        chk({31'd0, redirect_taken}, 0, "R7 below base not taken");
        @(negedge clk);
        ex_valid = 1'b0;
        chk({31'd0, target_err}, 1, "R7 below base err");

        // R10: writeback halt while running ignored
        do_reset();
        wb_halt = 1'b1;
        @(negedge clk);
        wb_halt = 1'b0;
        chk({31'd0, done}, 0, "R10 wb_halt ignored while running");

        // R8: halt squashed by same-cycle taken branch
        dec_halt = 1'b1;
        drive_ex(2'd2, 1'b0, 32'd4040, 32'd16, 32'd0);
        @(negedge clk);
        dec_halt = 1'b0; ex_valid = 1'b0;
        chk({31'd0, halted}, 0, "R8 squashed halt");
        chk(fetch_pc, 32'd4056, "R8 redirect wins");

        // R8: accepted halt freezes fetch
        dec_halt = 1'b1;
        prev = fetch_pc;
        @(negedge clk);
        dec_halt = 1'b0;
        chk({31'd0, halted}, 1, "R8 halted");
        chk(fetch_pc, prev, "R8 pc frozen");

        // R9: execute inputs ignored while halted
        drive_ex(2'd3, 1'b1, 32'd0, 32'd0, 32'd4800);
        #1;
        chk({31'd0, redirect_taken}, 0, "R9 no taken");
        chk({31'd0, flush_fd}, 0, "R9 no flush");
        @(negedge clk);
        drive_ex(2'd3, 1'b1, 32'd0, 32'd1, 32'd4800);
        @(negedge clk);
        ex_valid = 1'b0;
        chk(fetch_pc, prev, "R9 pc stable");
        chk({31'd0, target_err}, 0, "R9 no err");

        // R10: writeback halt completes
        wb_halt = 1'b1;
        @(negedge clk);
        wb_halt = 1'b0;
        chk({31'd0, done}, 1, "R10 done");
        @(negedge clk);
        chk({31'd0, done}, 1, "R10 done sticky");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule